// File: doc/BRIEF.md
# Coherent Read Conflict Filter

This block lives in the external agent that connects one processor to a shared snooping bus. It records the line address of every coherent read that the processor has issued and not yet completed. For each snoop seen on the bus it decides whether to pass the snoop on to the processor or to settle it locally. An intervention or invalidate aimed at a line the processor is still reading cannot find that line in the processor's cache. With detection enabled, the filter therefore answers the snoop itself.

A conflicting intervention is answered at once with a "line absent" result. A conflicting invalidate is dropped. A bus read response that hits a pending read is handled as an intervention that has already finished with the line absent. Snoops that do not conflict go to the processor, in arrival order, through a one-entry holding register with valid/ready flow control. Answers from the processor to forwarded interventions pass straight through to the result port. A saturating count of locally settled snoops is available for observation.

Top module: `coh_rd_filter`

## Requirements
- R1: After reset, no forwarded request and no result is pending, the pending-read table is empty, and the suppression count is zero.
- R2: With `detect_en_i` high, an accepted snoop of kind 0 (intervention) whose line matches a pending read is not forwarded. In the same cycle it raises `res_valid_o` with `res_local_o`=1, `res_present_o`=0 and `res_addr_o` = the snoop address with its offset bits cleared.
- R3: With `detect_en_i` high, an accepted snoop of kind 1 (invalidate) whose line matches a pending read is dropped. It produces no result and no forward.
- R4: With `detect_en_i` low, every accepted snoop of kind 0 or 1 is forwarded, whatever reads are pending.
- R5: A snoop of kind 2 (bus read response) is never forwarded. With detection on and a line match, it produces the same local absent result as R2. Kind 3 (other traffic) is ignored.
- R6: The match uses address bits [ADDR_W-1:5] only, so the five line-offset bits never affect a match.
- R7: A read issue makes its line matchable from the next cycle on. A read completion removes the line at once: a snoop in the completion cycle for that line is treated as not conflicting.
- R8: A forwarded request appears on `fwd_*` one cycle after acceptance and stays stable until `fwd_ready_i` is high. `snp_ready_o` is low while the holding register is full and `fwd_ready_i` is low. Requests leave in arrival order.
- R9: A processor answer (`cpu_resp_valid_i`) appears in the same cycle on the result port with `res_local_o`=0 and the processor's present flag and address. `snp_ready_o` is low in that cycle.
- R10: `sup_count_o` increases by one, one cycle after each accepted snoop of kind 0, 1 or 2 that matches while detection is on. It saturates at its maximum.
- R11: Up to DEPTH reads can be pending at once, and each one is matched on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| detect_en_i | input | 1 | Enable local conflict resolution |
| rd_issue_i | input | 1 | Processor issues a coherent read |
| rd_issue_addr_i | input | ADDR_W | Address of the issued read |
| rd_done_i | input | 1 | Processor coherent read completes |
| rd_done_addr_i | input | ADDR_W | Address of the completed read |
| snp_valid_i | input | 1 | Snoop present |
| snp_kind_i | input | 2 | 0 intervention, 1 invalidate, 2 read response, 3 other |
| snp_addr_i | input | ADDR_W | Snoop address |
| snp_ready_o | output | 1 | Snoop accepted this cycle when high with valid |
| fwd_valid_o | output | 1 | Request to processor valid |
| fwd_kind_o | output | 2 | Kind of forwarded request |
| fwd_addr_o | output | ADDR_W | Address of forwarded request |
| fwd_ready_i | input | 1 | Processor takes forwarded request |
| cpu_resp_valid_i | input | 1 | Processor intervention answer |
| cpu_resp_present_i | input | 1 | Processor holds the line |
| cpu_resp_addr_i | input | ADDR_W | Address of processor answer |
| res_valid_o | output | 1 | Intervention result valid |
| res_local_o | output | 1 | Result settled by the filter |
| res_present_o | output | 1 | Line present in processor cache |
| res_addr_o | output | ADDR_W | Result address |
| sup_count_o | output | CNT_W | Saturating count of locally settled snoops |

## Verification
The bench builds the filter with DEPTH=4, ADDR_W=32 and CNT_W=4. With a 4-bit count, the detect-on sweep drives the counter past its ceiling, so saturation is checked within a short run. The table fills completely, and the bench sweeps every snoop kind against all 32 offsets of a pending line and of a free line, with detection both on and off. It also covers a completion in the same cycle as a snoop, a read issue in the same cycle as a snoop, and a full holding register.

// File: rtl/coh_flt_pkg.sv
package coh_flt_pkg;
  typedef enum logic [1:0] {
    SNP_INTV  = 2'd0,
    SNP_INVL  = 2'd1,
    SNP_RDRSP = 2'd2,
    SNP_OTHER = 2'd3
  } snp_kind_e;
endpackage

// File: rtl/coh_pend_cam.sv
module coh_pend_cam #(
  parameter int DEPTH = 4,
  parameter int LW    = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [LW-1:0] set_line_i,
  input  logic          clr_i,
  input  logic [LW-1:0] clr_line_i,
  input  logic [LW-1:0] look_line_i,
  output logic          hit_o,
  output logic          full_o
);
  logic [DEPTH-1:0]         vld_q;
  logic [DEPTH-1:0][LW-1:0] line_q;
  logic [DEPTH-1:0]         clr_m, look_m, free_oh;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign clr_m[g]  = clr_i && vld_q[g] && (line_q[g] == clr_line_i);
    // completion wins over a same-cycle lookup
    assign look_m[g] = vld_q[g] && !clr_m[g] && (line_q[g] == look_line_i);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      line_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (set_i && free_oh[i]) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= set_line_i;
        end else if (clr_m[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  assign hit_o  = |look_m;
  assign full_o = &vld_q;

  assert_no_set_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !full_o);
  assert_set_grows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i |=> $countones(vld_q) == $past($countones(vld_q)) + 1);
  assert_clr_shrinks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> $countones(vld_q) <= $past($countones(vld_q)));
endmodule

// File: rtl/coh_fwd_hold.sv
module coh_fwd_hold #(
  parameter int PW = 34
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [PW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [PW-1:0] out_data_o,
  input  logic          out_ready_i
);
  logic          vld_q;
  logic [PW-1:0] dat_q;

  assign in_ready_o = !vld_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= in_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/coh_sup_cnt.sv
module coh_sup_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  assert_sat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&count_o) |=> (&count_o));
  assert_cnt_mono_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(count_o));
endmodule

// File: rtl/coh_rd_filter.sv
module coh_rd_filter
  import coh_flt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 5,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              detect_en_i,
  input  logic              rd_issue_i,
  input  logic [ADDR_W-1:0] rd_issue_addr_i,
  input  logic              rd_done_i,
  input  logic [ADDR_W-1:0] rd_done_addr_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_kind_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_ready_o,
  output logic              fwd_valid_o,
  output logic [1:0]        fwd_kind_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  input  logic              fwd_ready_i,
  input  logic              cpu_resp_valid_i,
  input  logic              cpu_resp_present_i,
  input  logic [ADDR_W-1:0] cpu_resp_addr_i,
  output logic              res_valid_o,
  output logic              res_local_o,
  output logic              res_present_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic [CNT_W-1:0]  sup_count_o
);
  localparam int LW = ADDR_W - OFFS_W;
  localparam int PW = ADDR_W + 2;

  snp_kind_e kind;
  logic      cam_hit, cam_full, conflict, snp_fire, hold_rdy, fwd_in, local_res, sup_inc;
  logic [PW-1:0] fwd_data;
  logic      unused_offs;

  assign kind = snp_kind_e'(snp_kind_i);
  assign unused_offs = ^{rd_issue_addr_i[OFFS_W-1:0], rd_done_addr_i[OFFS_W-1:0], cam_full};

  coh_pend_cam #(.DEPTH(DEPTH), .LW(LW)) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (rd_issue_i),
    .set_line_i (rd_issue_addr_i[ADDR_W-1:OFFS_W]),
    .clr_i      (rd_done_i),
    .clr_line_i (rd_done_addr_i[ADDR_W-1:OFFS_W]),
    .look_line_i(snp_addr_i[ADDR_W-1:OFFS_W]),
    .hit_o      (cam_hit),
    .full_o     (cam_full)
  );

  // processor answers own the result port; hold snoops off that cycle
  assign snp_ready_o = hold_rdy && !cpu_resp_valid_i;
  assign snp_fire    = snp_valid_i && snp_ready_o;
  assign conflict    = detect_en_i && cam_hit;
  assign fwd_in      = snp_fire && !conflict && (kind == SNP_INTV || kind == SNP_INVL);
  assign local_res   = snp_fire && conflict && (kind == SNP_INTV || kind == SNP_RDRSP);
  assign sup_inc     = snp_fire && conflict && (kind != SNP_OTHER);

  coh_fwd_hold #(.PW(PW)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (fwd_in),
    .in_data_i  ({snp_kind_i, snp_addr_i}),
    .in_ready_o (hold_rdy),
    .out_valid_o(fwd_valid_o),
    .out_data_o (fwd_data),
    .out_ready_i(fwd_ready_i)
  );
  assign fwd_kind_o = fwd_data[PW-1 -: 2];
  assign fwd_addr_o = fwd_data[ADDR_W-1:0];

  always_comb begin
    res_valid_o   = local_res || cpu_resp_valid_i;
    res_local_o   = local_res;
    res_present_o = cpu_resp_valid_i && cpu_resp_present_i;
    res_addr_o    = cpu_resp_valid_i ? cpu_resp_addr_i
                                     : {snp_addr_i[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
  end

  coh_sup_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sup_inc),
    .count_o(sup_count_o)
  );

  assert_hit_not_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_fire && conflict && kind == SNP_INTV
    |=> fwd_valid_o == ($past(fwd_valid_o) && !$past(fwd_ready_i)));
  assert_inv_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_fire && conflict && kind == SNP_INVL
    |-> !res_valid_o ##1 fwd_valid_o == ($past(fwd_valid_o) && !$past(fwd_ready_i)));
  assert_off_forwards_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_fire && !detect_en_i && (kind == SNP_INTV || kind == SNP_INVL) |=> fwd_valid_o);
  assert_rdrsp_never_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_fire && kind == SNP_RDRSP
    |=> fwd_valid_o == ($past(fwd_valid_o) && !$past(fwd_ready_i)));
  assert_cpu_res_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_local_o |-> cpu_resp_valid_i && !snp_fire);
endmodule

// File: tb/coh_rd_filter_tb_top.sv
module coh_rd_filter_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          detect_en = 0, rd_issue = 0, rd_done = 0, snp_valid = 0, fwd_ready = 0;
  logic          cpu_v = 0, cpu_p = 0;
  logic [1:0]    snp_kind = 0;
  logic [AW-1:0] rd_issue_addr = 0, rd_done_addr = 0, snp_addr = 0, cpu_addr = 0;
  logic          snp_ready, fwd_valid, res_valid, res_local, res_present;
  logic [1:0]    fwd_kind;
  logic [AW-1:0] fwd_addr, res_addr;
  logic [CW-1:0] sup_count;

  coh_rd_filter #(.ADDR_W(AW), .OFFS_W(5), .DEPTH(4), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .detect_en_i(detect_en),
    .rd_issue_i(rd_issue), .rd_issue_addr_i(rd_issue_addr),
    .rd_done_i(rd_done), .rd_done_addr_i(rd_done_addr),
    .snp_valid_i(snp_valid), .snp_kind_i(snp_kind), .snp_addr_i(snp_addr),
    .snp_ready_o(snp_ready), .fwd_valid_o(fwd_valid), .fwd_kind_o(fwd_kind),
    .fwd_addr_o(fwd_addr), .fwd_ready_i(fwd_ready),
    .cpu_resp_valid_i(cpu_v), .cpu_resp_present_i(cpu_p), .cpu_resp_addr_i(cpu_addr),
    .res_valid_o(res_valid), .res_local_o(res_local), .res_present_o(res_present),
    .res_addr_o(res_addr), .sup_count_o(sup_count)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit        pv [8];
  logic [26:0] pl [8];
  int        cnt_m = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [AW-1:0] a);
    for (int i = 0; i < 8; i++) if (pv[i] && pl[i] == a[AW-1:5]) return 1;
    return 0;
  endfunction

  function automatic void m_add(input logic [AW-1:0] a);
    for (int i = 0; i < 8; i++) if (!pv[i]) begin pv[i] = 1; pl[i] = a[AW-1:5]; return; end
  endfunction

  function automatic void m_del(input logic [AW-1:0] a);
    for (int i = 0; i < 8; i++) if (pv[i] && pl[i] == a[AW-1:5]) pv[i] = 0;
  endfunction

  task automatic issue(input logic [AW-1:0] a);
    @(negedge clk); rd_issue = 1; rd_issue_addr = a;
    @(negedge clk); rd_issue = 0; m_add(a);
  endtask

  task automatic complete(input logic [AW-1:0] a);
    @(negedge clk); rd_done = 1; rd_done_addr = a;
    @(negedge clk); rd_done = 0; m_del(a);
  endtask

  task automatic consume();
    fwd_ready = 1;
    @(negedge clk); fwd_ready = 0; #1;
    chk("R8 drained", fwd_valid, 0);
  endtask

  // one snoop, hold register assumed empty; checks R2..R6, R10
  task automatic snoop(input logic [1:0] k, input logic [AW-1:0] a, input string req);
    bit hit, loc, fwd;
    @(negedge clk); snp_valid = 1; snp_kind = k; snp_addr = a; #1;
    hit = detect_en && m_hit(a);
    loc = hit && (k == 0 || k == 2);
    fwd = !hit && (k < 2);
    chk({req, " ready"}, snp_ready, 1);
    chk({req, " res_valid"}, res_valid, loc);
    chk({req, " res_local"}, res_local, loc);
    if (loc) begin
      chk({req, " R2 absent"}, res_present, 0);
      chk({req, " R2 res_addr"}, res_addr, {a[AW-1:5], 5'd0});
    end
    if (hit && k != 3 && cnt_m < 15) cnt_m++;
    @(negedge clk); snp_valid = 0; #1;
    chk({req, " fwd_valid"}, fwd_valid, fwd);
    chk({req, " R10 count"}, sup_count, cnt_m);
    if (fwd) begin
      chk({req, " fwd_addr"}, fwd_addr, a);
      chk({req, " fwd_kind"}, fwd_kind, k);
      consume();
    end
  endtask

  localparam logic [AW-1:0] BASE = 32'h1000_0000;

  initial begin
    for (int i = 0; i < 8; i++) pv[i] = 0;
    #20; @(negedge clk); rst_n = 1; #1;
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 count", sup_count, 0);
    chk("R1 ready", snp_ready, 1);
    detect_en = 1;
    snoop(2'd0, BASE, "R1 empty table");

    for (int i = 0; i < 4; i++) issue(BASE + AW'(i) * 32'h40);
    for (int i = 0; i < 4; i++) snoop(2'd0, BASE + AW'(i) * 32'h40 + 32'd7, "R11 each entry");
    snoop(2'd1, BASE + 32'h20, "R11 neighbour line");

    for (int d = 0; d < 2; d++) begin
      detect_en = d[0];
      for (int k = 0; k < 4; k++)
        for (int o = 0; o < 32; o++) begin
          snoop(k[1:0], BASE + 32'h80 + AW'(o), d ? "R6 R3 R5 detect on" : "R4 detect off");
          snoop(k[1:0], 32'h2000_0000 + AW'(o), "R6 free line");
        end
    end
    chk("R10 saturated", sup_count, 15);

    detect_en = 1;
    complete(BASE + 32'h40);
    snoop(2'd0, BASE + 32'h40, "R7 after completion");

    // completion and snoop in the same cycle
    @(negedge clk); rd_done = 1; rd_done_addr = BASE + 32'h80;
    snp_valid = 1; snp_kind = 2'd0; snp_addr = BASE + 32'h83; #1;
    chk("R7 same-cycle no local", res_valid, 0);
    @(negedge clk); rd_done = 0; snp_valid = 0; m_del(BASE + 32'h80); #1;
    chk("R7 same-cycle forwarded", fwd_valid, 1);
    consume();

    // issue and snoop in the same cycle: not yet matched
    @(negedge clk); rd_issue = 1; rd_issue_addr = BASE + 32'h140;
    snp_valid = 1; snp_kind = 2'd0; snp_addr = BASE + 32'h140; #1;
    chk("R7 issue not yet visible", res_valid, 0);
    @(negedge clk); rd_issue = 0; snp_valid = 0; m_add(BASE + 32'h140); #1;
    chk("R7 issue-cycle forwarded", fwd_valid, 1);
    consume();
    snoop(2'd0, BASE + 32'h15f, "R7 issue visible next cycle");

    // backpressure and ordering
    detect_en = 0;
    @(negedge clk); snp_valid = 1; snp_kind = 2'd1; snp_addr = 32'h3000_0004;
    @(negedge clk); snp_kind = 2'd0; snp_addr = 32'h3000_0044; #1;
    chk("R8 ready low when full", snp_ready, 0);
    chk("R8 first held", fwd_addr, 32'h3000_0004);
    @(negedge clk); #1;
    chk("R8 still held", fwd_addr, 32'h3000_0004);
    chk("R8 still held kind", fwd_kind, 1);
    fwd_ready = 1; #1;
    chk("R8 ready with sink", snp_ready, 1);
    @(negedge clk); fwd_ready = 0; snp_valid = 0; #1;
    chk("R8 second in order", fwd_addr, 32'h3000_0044);
    chk("R8 second valid", fwd_valid, 1);
    consume();

    // processor answer pass-through
    @(negedge clk); cpu_v = 1; cpu_p = 1; cpu_addr = 32'h4000_0020;
    snp_valid = 1; snp_kind = 2'd0; snp_addr = 32'h5000_0000; #1;
    chk("R9 res_valid", res_valid, 1);
    chk("R9 res_local", res_local, 0);
    chk("R9 present", res_present, 1);
    chk("R9 addr", res_addr, 32'h4000_0020);
    chk("R9 snoop stalled", snp_ready, 0);
    @(negedge clk); cpu_v = 0; cpu_p = 0; snp_valid = 0; #1;
    chk("R9 no forward while stalled", fwd_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule